// File: doc/BRIEF.md
# Auxiliary Time Snapshot and Event Unit

This block sits next to a free-running 64-bit time counter, kept in 32 ns units, and watches two asynchronous auxiliary inputs. A rising edge on either input freezes the current time into that channel's own 64-bit capture register. A rising edge on the first input is the slave-side snapshot. A rising edge on the second input is the master-side snapshot. The block also compares the time with a programmable 64-bit target. It accepts a one-cycle pulse-per-second strobe from the counter as a fourth event source.

All four conditions land in one event register that the host clears by writing 1. Each event has a mask bit in a control register. A single interrupt line is raised whenever any unmasked event is pending. The host reads captured times and the target as low and high 32-bit words. It acknowledges all serviced events with one write to the event register.

Top module: `aux_snap_event`

## Requirements
- R1: After reset, the event and control registers read 0, both capture pairs read 0, both target words read 0xFFFFFFFF, and irq is low.
- R2: A rising edge on aux_a passes two synchronising flops. On the third clock edge after the input rises, that edge copies cur_time into the channel A pair (address 4 = low word, address 5 = high word) and sets event bit 2.
- R3: A rising edge on aux_b behaves the same way. It loads the channel B pair (address 6 = low, address 7 = high) and sets event bit 3, and it leaves channel A untouched.
- R4: An auxiliary input that is held high captures only once. Later changes of cur_time do not reach the capture pair until a new rising edge arrives.
- R5: A new edge on a channel whose event bit is still set replaces the captured value, and the event bit stays set.
- R6: Event bit 1 sets on every cycle in which cur_time, compared as an unsigned 64-bit value, is at least the target. The target low word is at address 2 and the high word at address 3. A write-1 clear while the condition still holds leaves the bit set.
- R7: The event register is at address 1, with events in bits 4..1. Writing 1 to a bit clears it, writing 0 leaves it unchanged, and one write can clear several bits. Bits never clear without such a write.
- R8: A one-cycle pps_pulse sets event bit 4.
- R9: irq equals the OR of the event bits ANDed with the control mask bits. The control register is at address 0, with masks in bits 4..1 aligned to the event bits. Masked events are still recorded.
- R10: Writes to the capture addresses 4..7 have no effect on the captured values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cur_time | input | 64 | Running time value in 32 ns units |
| aux_a | input | 1 | Asynchronous slave-side snapshot input |
| aux_b | input | 1 | Asynchronous master-side snapshot input |
| pps_pulse | input | 1 | One-cycle pulse-per-second strobe |
| wr_en | input | 1 | Host register write strobe |
| wr_addr | input | 3 | Host write address |
| wr_data | input | 32 | Host write data |
| rd_addr | input | 3 | Host read address |
| rd_data | output | 32 | Read data for rd_addr (combinational) |
| irq | output | 1 | Combined interrupt request |

## Verification
The two snapshot inputs are pulsed at different, distinctive time values, so any crossed channel or swapped word shows up at once. A held-high input is followed by a change of time; a stale or repeated capture then shows in the pair. The target is brought from below to exactly equal, and then cleared while still equal, which separates a true greater-or-equal compare from an equality pulse and shows that the set overrides the clear. Mask patterns that select one pending event, and then only a non-pending one, separate a masked OR from an unmasked one. Write-1 and write-0 patterns to the event register, plus writes to capture addresses, show which writes have an effect.

// File: rtl/aux_snap_event.sv
module aux_snap_event #(
  parameter int HW   = 32,
  parameter int SYNC = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [2*HW-1:0] cur_time,
  input  logic            aux_a,
  input  logic            aux_b,
  input  logic            pps_pulse,
  input  logic            wr_en,
  input  logic [2:0]      wr_addr,
  input  logic [HW-1:0]   wr_data,
  input  logic [2:0]      rd_addr,
  output logic [HW-1:0]   rd_data,
  output logic            irq
);
  localparam int TW = 2 * HW;
  localparam logic [2:0] A_CTRL = 3'd0, A_EVT = 3'd1, A_TLO = 3'd2, A_THI = 3'd3,
                         A_ALO  = 3'd4, A_AHI = 3'd5, A_BLO = 3'd6, A_BHI = 3'd7;

  logic [SYNC:0]   sa, sb;
  logic [TW-1:0]   cap_a, cap_b, tgt;
  logic [4:1]      evt, mask, set_v, clr_v;
  logic            rise_a, rise_b, hit;

  assign rise_a = sa[SYNC-1] & ~sa[SYNC];
  assign rise_b = sb[SYNC-1] & ~sb[SYNC];
  assign hit    = cur_time >= tgt;
  assign set_v  = {pps_pulse, rise_b, rise_a, hit};
  assign clr_v  = (wr_en && wr_addr == A_EVT) ? wr_data[4:1] : 4'b0;
  assign irq    = |(evt & mask);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sa    <= '0;
      sb    <= '0;
      cap_a <= '0;
      cap_b <= '0;
      tgt   <= '1;
      evt   <= '0;
      mask  <= '0;
    end else begin
      sa  <= {sa[SYNC-1:0], aux_a};
      sb  <= {sb[SYNC-1:0], aux_b};
      if (rise_a) cap_a <= cur_time;
      if (rise_b) cap_b <= cur_time;
      if (wr_en) begin
        case (wr_addr)
          A_CTRL:  mask          <= wr_data[4:1];
          A_TLO:   tgt[HW-1:0]   <= wr_data;
          A_THI:   tgt[TW-1:HW]  <= wr_data;
          default: ;
        endcase
      end
      evt <= (evt & ~clr_v) | set_v;
    end
  end

  always_comb begin
    rd_data = '0;
    case (rd_addr)
      A_CTRL: rd_data[4:1] = mask;
      A_EVT:  rd_data[4:1] = evt;
      A_TLO:  rd_data = tgt[HW-1:0];
      A_THI:  rd_data = tgt[TW-1:HW];
      A_ALO:  rd_data = cap_a[HW-1:0];
      A_AHI:  rd_data = cap_a[TW-1:HW];
      A_BLO:  rd_data = cap_b[HW-1:0];
      A_BHI:  rd_data = cap_b[TW-1:HW];
      default: ;
    endcase
  end

  p_cap_a_r2: assert property (@(posedge clk) disable iff (!rst_n)
    rise_a |=> (evt[2] && cap_a == $past(cur_time)));
  p_cap_b_r3: assert property (@(posedge clk) disable iff (!rst_n)
    rise_b |=> (evt[3] && cap_b == $past(cur_time)));
  p_hold_a_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !rise_a |=> $stable(cap_a));
  p_target_r6: assert property (@(posedge clk) disable iff (!rst_n)
    hit |=> evt[1]);
  p_only_w1c_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(evt[3]) |-> $past(wr_en && wr_addr == A_EVT && wr_data[3]));
  p_pps_r8: assert property (@(posedge clk) disable iff (!rst_n)
    pps_pulse |=> evt[4]);
endmodule

// File: tb/aux_snap_event_test.sv
`timescale 1ns/1ps
module aux_snap_event_test;
  logic        clk = 0, rst_n = 0;
  logic [63:0] cur_time = 64'd0;
  logic        aux_a = 0, aux_b = 0, pps_pulse = 0;
  logic        wr_en = 0;
  logic [2:0]  wr_addr = 0, rd_addr = 0;
  logic [31:0] wr_data = 0;
  logic [31:0] rd_data;
  logic        irq;

  int nvec = 0, nbad = 0;
  bit done = 0;

  logic [3:0]  qa[$];
  logic [31:0] qv[$];
  string       qt[$];

  aux_snap_event uut (.clk, .rst_n, .cur_time, .aux_a, .aux_b, .pps_pulse,
                      .wr_en, .wr_addr, .wr_data, .rd_addr, .rd_data, .irq);

  always #4 clk = ~clk;

  // address 8 selects the irq pin instead of a register
  task automatic expect_val(input logic [3:0] a, input logic [31:0] v, input string t);
    qa.push_back(a); qv.push_back(v); qt.push_back(t);
  endtask

  task automatic drain();
    while (qa.size() != 0) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 0;
  endtask

  task automatic settle(); repeat (4) @(negedge clk); endtask

  always begin
    @(negedge clk);
    if (qa.size() != 0) begin
      logic [3:0] a; logic [31:0] v, got; string t;
      a = qa.pop_front(); v = qv.pop_front(); t = qt.pop_front();
      if (a < 8) rd_addr = a[2:0];
      #1;
      got = (a == 8) ? {31'b0, irq} : rd_data;
      nvec++;
      if (got !== v) begin
        nbad++;
        $display("FAIL %s addr %0d: got %h expected %h", t, a, got, v);
      end
    end
  end

  initial begin
    #(200000 * 8);
    if (!done) begin
      nbad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    expect_val(0, 0, "R1"); expect_val(1, 0, "R1");
    expect_val(2, 32'hFFFFFFFF, "R1"); expect_val(3, 32'hFFFFFFFF, "R1");
    expect_val(4, 0, "R1"); expect_val(7, 0, "R1"); expect_val(8, 0, "R1");
    drain();

    // R2 channel A capture
    cur_time = 64'h12345678_9ABCDEF0;
    aux_a = 1; settle();
    expect_val(4, 32'h9ABCDEF0, "R2"); expect_val(5, 32'h12345678, "R2");
    expect_val(1, 32'h04, "R2"); expect_val(8, 0, "R9");
    drain();

    // R4 held high: no second capture
    cur_time = 64'h0BAD0000_0000BEEF; settle();
    expect_val(4, 32'h9ABCDEF0, "R4"); expect_val(5, 32'h12345678, "R4");
    drain();
    aux_a = 0; settle();

    // R3 channel B capture, channel A untouched
    cur_time = 64'h00000ABC_DEF01234;
    aux_b = 1; settle(); aux_b = 0; settle();
    expect_val(6, 32'hDEF01234, "R3"); expect_val(7, 32'h00000ABC, "R3");
    expect_val(4, 32'h9ABCDEF0, "R3"); expect_val(1, 32'h0C, "R3");
    drain();

    // R10 writes to capture addresses ignored
    wr(3'd4, 32'h0); wr(3'd7, 32'hFFFF0000);
    expect_val(4, 32'h9ABCDEF0, "R10"); expect_val(7, 32'h00000ABC, "R10");
    drain();

    // R9 masking
    wr(3'd0, 32'h08);
    expect_val(0, 32'h08, "R9"); expect_val(8, 1, "R9");
    drain();
    wr(3'd0, 32'h10);
    expect_val(8, 0, "R9"); expect_val(1, 32'h0C, "R9");
    drain();
    wr(3'd0, 32'h0);

    // R5 new edge overwrites while flag set
    cur_time = 64'h00000001_00000007;
    aux_a = 1; settle(); aux_a = 0; settle();
    expect_val(4, 32'h00000007, "R5"); expect_val(5, 32'h00000001, "R5");
    expect_val(1, 32'h0C, "R5");
    drain();

    // R7 write-1-to-clear
    wr(3'd1, 32'h0);
    expect_val(1, 32'h0C, "R7");
    drain();
    wr(3'd1, 32'h08);
    expect_val(1, 32'h04, "R7");
    drain();
    wr(3'd1, 32'h0C);
    expect_val(1, 32'h00, "R7");
    drain();

    // R6 target compare
    cur_time = 64'h00000001_00000000;
    wr(3'd3, 32'h1); wr(3'd2, 32'h10); settle();
    expect_val(1, 32'h00, "R6"); expect_val(2, 32'h10, "R6");
    drain();
    cur_time = 64'h00000001_00000010; settle();
    expect_val(1, 32'h02, "R6");
    drain();
    wr(3'd1, 32'h02);
    expect_val(1, 32'h02, "R6");
    drain();
    wr(3'd3, 32'h2); wr(3'd1, 32'h02); settle();
    expect_val(1, 32'h00, "R6");
    drain();

    // R8 pulse-per-second
    @(negedge clk); pps_pulse = 1; @(negedge clk); pps_pulse = 0;
    settle();
    expect_val(1, 32'h10, "R8"); expect_val(8, 0, "R9");
    drain();
    wr(3'd0, 32'h10);
    expect_val(8, 1, "R8");
    drain();
    wr(3'd1, 32'h1E);
    expect_val(1, 32'h00, "R7"); expect_val(8, 0, "R9");
    drain();

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
    $finish;
  end
endmodule